// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous static RAM with an 18-bit address and an 8-bit data bus. The host raises a one-cycle request strobe with a write flag, an address and write data. The controller then plays out the matching pin sequence on the memory side and raises a one-cycle done pulse when the cycle is over. For reads, the captured byte is presented on the read-data output together with done.

The memory has two chip enables of opposite polarity: one active-low and one active-high. It has active-low write and output enables and a data bus that is split into drive, drive-enable and input. Every phase length is derived from nanosecond limits and the clock period. Each count is the ceiling of limit over period, with a floor of one cycle. Between operations the memory is held deselected. When a write follows a read, a bus turnaround gap keeps the controller from driving the data pins while the memory may still be driving them.

Top module: `async_sram_ctl`

## Requirements
- R1: While idle, and in the cycle done is high, the active-low enable is 1, the active-high enable is 0, write and output enables are both 1, and the data drive enable is 0. Done is 0 after reset.
- R2: A read selects the memory with write enable high and output enable low for RD_CYC = max(ceil(55/T), ceil(30/T), 1) cycles (T the clock period in ns). At the end of those cycles the input bus is captured into the read-data output. Done rises RD_CYC+1 clock edges after the edge that accepts the request (8 with T = 8).
- R3: A write selects the memory and holds write enable low for WR_CYC = max(ceil(55/T), ceil(30/T), ceil(25/T), 1) consecutive cycles (7 with T = 8). During that time the write data is driven and the drive enable is set. Done rises WR_CYC+1 edges after acceptance, and the memory then holds the byte.
- R4: The memory address does not change while write enable is low.
- R5: The data drive enable is never 1 while output enable is 0.
- R6: A write whose previous operation was a read is preceded by TURN_CYC = max(ceil(25/T), 1) deselected cycles. Its done then rises TURN_CYC+WR_CYC+1 edges after acceptance (12 with T = 8).
- R7: Each accepted request produces exactly one done pulse, one cycle long.
- R8: A request raised while an operation is in progress is ignored. It produces no done and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle request strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Captured read data |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data to drive onto the memory bus |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | DATA_W | Data read from the memory bus |

## Verification
The default period is 8 ns. With it, done for a plain read or write is due 8 clock edges after the accepting edge, and a write that follows a read is due after 12. The driver records the cycle count at which each request is accepted and pushes the expected latency and data into a queue. The monitor samples on the falling edge and compares the elapsed cycle count exactly whenever done appears. Write-enable pulse length and address stability are measured at the memory-model side on every rising edge.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_TURN  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    // ceiling of a nanosecond limit over the clock period, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int RD_CYC   = 7,
    parameter int WR_CYC   = 7,
    parameter int TURN_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             write,
    input  logic             cnt_expired,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             accept,
    output logic             capture,
    output logic             done,
    output phase_e           phase
);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

    phase_e state_q, state_d;
    logic   last_rd_q, last_rd_d;
    logic   done_q, done_d;

    always_comb begin
        state_d   = state_q;
        last_rd_d = last_rd_q;
        done_d    = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    if (!write) begin
                        state_d = PH_READ;
                        cnt_val = RD_LAST;
                    end else if (last_rd_q) begin
                        state_d = PH_TURN;
                        cnt_val = TURN_LAST;
                    end else begin
                        state_d = PH_WRITE;
                        cnt_val = WR_LAST;
                    end
                end
            end
            PH_READ: begin
                if (cnt_expired) begin
                    capture   = 1'b1;
                    done_d    = 1'b1;
                    last_rd_d = 1'b1;
                    state_d   = PH_IDLE;
                end
            end
            PH_TURN: begin
                if (cnt_expired) begin
                    cnt_load = 1'b1;
                    cnt_val  = WR_LAST;
                    state_d  = PH_WRITE;
                end
            end
            PH_WRITE: begin
                if (cnt_expired) begin
                    done_d    = 1'b1;
                    last_rd_d = 1'b0;
                    state_d   = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PH_IDLE;
            last_rd_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            last_rd_q <= last_rd_d;
            done_q    <= done_d;
        end
    end

    assign phase = state_q;
    assign done  = done_q;
endmodule

// File: rtl/sram_req_reg.sv
module sram_req_reg #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t req_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                req_q.addr  <= in_addr;
                req_q.wdata <= in_wdata;
            end
            if (capture)
                rdata_q <= bus_in;
        end
    end

    assign held_addr  = req_q.addr;
    assign held_wdata = req_q.wdata;
    assign rdata      = rdata_q;
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_OE_NS       = 30,
    parameter int T_WC_NS       = 55,
    parameter int T_AW_NS       = 55,
    parameter int T_WP_NS       = 30,
    parameter int T_DW_NS       = 25,
    parameter int T_OHZ_NS      = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC   = int'(max2(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                                        ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
    localparam int WR_CYC   = int'(max2(max2(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                        max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_DW_NS, CLK_PERIOD_NS))));
    localparam int TURN_CYC = int'(ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC  = int'(max2(max2(RD_CYC, WR_CYC), TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_expired;
    logic             accept;
    logic             capture;
    phase_e           phase;
    logic             selected;

    sram_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    sram_seq_fsm #(
        .CNT_W   (CNT_W),
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .TURN_CYC(TURN_CYC)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .req         (host_req),
        .write       (host_write),
        .cnt_expired (cnt_expired),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val),
        .accept      (accept),
        .capture     (capture),
        .done        (host_done),
        .phase       (phase)
    );

    sram_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) req_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .in_addr    (host_addr),
        .in_wdata   (host_wdata),
        .bus_in     (mem_dq_in),
        .held_addr  (mem_addr),
        .held_wdata (mem_dq_out),
        .rdata      (host_rdata)
    );

    // strobes decode straight from the registered phase
    assign selected  = (phase == PH_READ) || (phase == PH_WRITE);
    assign mem_ce_n  = !selected;
    assign mem_ce    = selected;
    assign mem_we_n  = (phase != PH_WRITE);
    assign mem_oe_n  = (phase != PH_READ);
    assign mem_dq_oe = (phase == PH_WRITE);
endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              host_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    // R3: write strobe only while both enables select the memory, with data driven
    a_r3_write_selected: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_dq_oe));

    // R4: address frozen across consecutive write-low cycles
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> (mem_we_n || $stable(mem_addr)));

    // R5: never drive while memory outputs are enabled
    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R6: drivers turn on only after a cycle with output enable high
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R2: read strobe only with memory selected and write enable high
    a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && mem_ce));

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);

    // R1: both enables always agree on selection
    a_r1_enable_pair: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n == !mem_ce);
endmodule

bind async_sram_ctl async_sram_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .host_done (host_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/async_sram_ctl_tb_top.sv
module async_sram_ctl_tb_top;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int LAT_PLAIN = 8;   // RD_CYC/WR_CYC (7) + 1 at 8 ns
    localparam int LAT_TURN  = 12;  // TURN_CYC (4) + WR_CYC (7) + 1
    localparam int WE_RUN    = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_done;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    always #4 clk = ~clk;

    async_sram_ctl dut_i (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_done(host_done),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // ---------------- memory model ----------------
    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] ref_mem   [int];
    wire model_sel = !mem_ce_n && mem_ce;

    always @(*) begin
        if (model_sel && mem_we_n && !mem_oe_n)
            mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
        else
            mem_dq_in = '0;
    end

    int            we_run = 0;
    logic [AW-1:0] we_addr = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (!mem_we_n && model_sel) begin
                model_mem[int'(mem_addr)] = mem_dq_out;
                if (we_run > 0) begin
                    compared++;
                    if (mem_addr !== we_addr) begin
                        mismatched++;
                        $display("FAIL R4 address moved during write: act %h exp %h", mem_addr, we_addr);
                    end
                end
                we_addr = mem_addr;
                we_run++;
            end else if (we_run > 0) begin
                compared++;
                if (we_run != WE_RUN) begin
                    mismatched++;
                    $display("FAIL R3 write pulse length: act %0d exp %0d", we_run, WE_RUN);
                end
                we_run = 0;
            end
            if (mem_dq_oe && !mem_oe_n) begin
                compared++;
                mismatched++;
                $display("FAIL R5 drive overlap: act oe_n=%b exp 1", mem_oe_n);
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            wr;
        logic [DW-1:0] data;
        int            issue;
        int            lat;
    } exp_t;
    exp_t sb_q[$];
    bit   prev_read = 1'b0;

    task automatic check_idle(input string tag);
        compared++;
        if (!(mem_ce_n === 1'b1 && mem_ce === 1'b0 && mem_we_n === 1'b1 &&
              mem_oe_n === 1'b1 && mem_dq_oe === 1'b0)) begin
            mismatched++;
            $display("FAIL R1 %s idle pins: act ce_n=%b ce=%b we_n=%b oe_n=%b oe=%b exp 1 0 1 1 0",
                     tag, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && host_done) begin
            compared++;
            if (sb_q.size() == 0) begin
                mismatched++;
                $display("FAIL R7/R8 unexpected done: act 1 exp 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (cyc - e.issue != e.lat) begin
                    mismatched++;
                    $display("FAIL %s latency: act %0d exp %0d",
                             e.lat == LAT_TURN ? "R6" : (e.wr ? "R3" : "R2"), cyc - e.issue, e.lat);
                end
                if (!e.wr) begin
                    compared++;
                    if (host_rdata !== e.data) begin
                        mismatched++;
                        $display("FAIL R2 read data: act %h exp %h", host_rdata, e.data);
                    end
                end
                check_idle("after done");
            end
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int intrude);
        exp_t e;
        @(negedge clk);
        host_req   = 1'b1;
        host_write = wr;
        host_addr  = a;
        host_wdata = d;
        e.wr    = wr;
        e.issue = cyc;
        e.lat   = (wr && prev_read) ? LAT_TURN : LAT_PLAIN;
        if (wr) begin
            ref_mem[int'(a)] = d;
            e.data = d;
        end else begin
            e.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
        end
        prev_read = !wr;
        sb_q.push_back(e);
        @(negedge clk);
        host_req = 1'b0;
        if (intrude > 0) begin
            // R8: request while busy, must be dropped
            repeat (intrude) @(negedge clk);
            host_req   = 1'b1;
            host_write = 1'b1;
            host_addr  = 18'h00777;
            host_wdata = 8'hEE;
            @(negedge clk);
            host_req = 1'b0;
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("reset");
        compared++;
        if (host_done !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 done after reset: act %b exp 0", host_done);
        end

        issue(1'b1, 18'h00000, 8'hA5, 0);          // R3 lowest address
        issue(1'b1, 18'h3FFFF, 8'h5A, 0);          // R3 highest address
        issue(1'b0, 18'h00000, 8'h00, 0);          // R2
        issue(1'b0, 18'h3FFFF, 8'h00, 0);          // R2 read after read
        issue(1'b1, 18'h00010, 8'hFF, 0);          // R6 write after read
        issue(1'b1, 18'h00011, 8'h00, 0);          // R3 write after write
        issue(1'b0, 18'h00010, 8'h00, 0);
        issue(1'b0, 18'h00011, 8'h00, 0);
        issue(1'b1, 18'h00777, 8'h11, 0);
        issue(1'b0, 18'h00001, 8'h00, 2);          // R8 intrusion during read
        issue(1'b1, 18'h00002, 8'h22, 3);          // R8 intrusion during write
        issue(1'b0, 18'h00777, 8'h00, 0);          // R8 must still read 11
        for (int i = 0; i < 12; i++) begin
            logic [AW-1:0] a;
            a = AW'((i * 7919 + 13) % 262144);
            issue(1'b1, a, DW'(i * 37 + 3), 0);
            if (i % 3 == 0) issue(1'b0, a, 8'h00, 0);
        end
        for (int i = 0; i < 12; i++)
            issue(1'b0, AW'((i * 7919 + 13) % 262144), 8'h00, 0);

        repeat (4) @(negedge clk);
        check_idle("end");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule